// File: doc/BRIEF.md
# UART Xon/Xoff Software Flow Controller

This block sits between a UART receiver and its receive FIFO, and beside the transmitter. It checks every received character against four programmable control codes: a resume pair and a pause pair. A matching character, or a matching ordered pair, pauses or resumes the local transmitter. Characters taken as control codes are kept out of the FIFO. Only the low 5 to 8 bits of each character are compared, as set by the character-length select.

The block also compares the FIFO fill count with a trigger level. When the count climbs above the level, it asks the transmitter to send the pause code or codes to the far end. When the count later falls under the level, it asks for the resume code or codes. Each request is held until the transmitter acknowledges the character. A separate marker mode leaves flow matching off and raises a flag when a character equals the second pause code. That character is still written to the FIFO.

Top module: `swFlowCtl`

## Requirements
- R1: The four code registers reset to zero and are loaded by `cfgWe`; `cfgAddr` 0 selects resume-1, 1 selects resume-2, 2 selects pause-1 and 3 selects pause-2.
- R2: When `rxFlowEn`=1 and `dblMode`=0, a received character equal to pause-1 sets `txPause` on the next cycle, and one equal to resume-1 clears it; both are withheld from the FIFO (`fifoWe` low in that cycle). When the two codes are equal, pause wins.
- R3: When `rxFlowEn`=1 and `dblMode`=1, `txPause` is set only after pause-1 is immediately followed by pause-2, and cleared only after resume-1 is immediately followed by resume-2. A lone second code is ordinary data.
- R4: In pair mode, every character that matches a first code is withheld. If the next character does not complete the pair, the partial match is dropped, and that character is judged again as a possible first code.
- R5: Only the low 5+`wordLen` bits (`wordLen` 0..3 gives 5..8 bits) of the character and the codes take part in a compare.
- R6: A character that is not taken as a control code is written (`fifoWe`=`rxValid`). `txPause` changes only in the cycle after a received control character. With `rxFlowEn`=0, nothing is matched.
- R7: With `specialEn`=1 and `rxFlowEn`=0, a character equal to pause-2 raises `specialHit` in its `rxValid` cycle and is still written. With `rxFlowEn`=1, `specialHit` stays low.
- R8: With `autoEn`=1, the first cycle in which `fifoCount` > `trigLevel` starts a pause request: `ctlReq` rises one cycle later with `ctlChar`=pause-1. The request is held until `txCtlAck`, and it is issued only once until a resume has been requested.
- R9: After a pause request, the first cycle in which `fifoCount` < `trigLevel` starts a resume request with `ctlChar`=resume-1. A count equal to the trigger level starts neither request.
- R10: With `dblMode`=1, an acknowledged first code is followed by the second code of the same pair (pause-2 or resume-2). After that second code is acknowledged, `ctlReq` drops.
- R11: After reset, `txPause`, `ctlReq` and `specialHit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Code register write strobe |
| cfgAddr | input | 2 | Code register select |
| cfgData | input | CHAR_W | Code register write data |
| rxFlowEn | input | 1 | Enable matching of received control codes |
| dblMode | input | 1 | Use two-character codes for matching and sending |
| autoEn | input | 1 | Enable threshold-driven code requests |
| specialEn | input | 1 | Enable the marker-character flag |
| wordLen | input | 2 | Compared width is 5 + wordLen bits |
| rxValid | input | 1 | Received character strobe |
| rxChar | input | CHAR_W | Received character |
| fifoCount | input | CNT_W | Current receive FIFO fill count |
| trigLevel | input | CNT_W | Fill trigger level |
| txCtlAck | input | 1 | Transmitter has taken the requested control character |
| txPause | output | 1 | Hold the transmitter after its current character |
| ctlReq | output | 1 | Request to send `ctlChar` |
| ctlChar | output | CHAR_W | Control character to send |
| fifoWe | output | 1 | Write enable toward the receive FIFO |
| specialHit | output | 1 | Marker character seen |

## Verification
The assertions check on every cycle that a pause-1 match in single mode sets `txPause`, and that `txPause` holds without a received character. They also check that a pending request and its character stay stable until acknowledged, and that a flagged marker character is always written. Only the bench's scenarios can show the pair ordering with the re-judging of a broken pair, the compare-width masking, the once-per-crossing rule at the trigger level, and the exact order of the two-character transmit sequence.

// File: rtl/flowPkg.sv
package flowPkg;
  typedef struct packed {
    logic xon1;
    logic xon2;
    logic xoff1;
    logic xoff2;
  } codeHitT;

  typedef struct packed {
    logic drop;
    logic sendXoff;
    logic sendSecond;
  } ctlStrbT;

  typedef enum logic [1:0] {PEND_NONE, PEND_XON, PEND_XOFF} pendT;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_FIRST, SEQ_SECOND} seqT;
endpackage

// File: rtl/flowData.sv
module flowData
  import flowPkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CHAR_W-1:0] cfgData,
  input  logic [1:0]        wordLen,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  ctlStrbT           strb,
  output codeHitT           hit,
  output logic              fifoWe,
  output logic [CHAR_W-1:0] ctlChar
);
  localparam int MIN_W = 5;
  localparam int N_CODES = 4;

  logic [CHAR_W-1:0] codeReg [N_CODES];
  logic [CHAR_W-1:0] cmpMask;
  logic [N_CODES-1:0] hitVec;

  // Code registers: 0 resume-1, 1 resume-2, 2 pause-1, 3 pause-2 (R1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_CODES; i++) codeReg[i] <= '0;
    end else if (cfgWe) begin
      codeReg[cfgAddr] <= cfgData;
    end
  end

  // Compare width follows the character length (R5)
  always_comb begin
    for (int i = 0; i < CHAR_W; i++) cmpMask[i] = (i < MIN_W + int'(wordLen));
  end

  for (genvar g = 0; g < N_CODES; g++) begin : gCmp
    assign hitVec[g] = ((rxChar ^ codeReg[g]) & cmpMask) == '0;
  end

  assign hit.xon1  = hitVec[0];
  assign hit.xon2  = hitVec[1];
  assign hit.xoff1 = hitVec[2];
  assign hit.xoff2 = hitVec[3];

  assign fifoWe  = rxValid & ~strb.drop;
  assign ctlChar = codeReg[{strb.sendXoff, strb.sendSecond}];
endmodule

// File: rtl/flowCtrl.sv
module flowCtrl
  import flowPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxFlowEn,
  input  logic             dblMode,
  input  logic             autoEn,
  input  logic             specialEn,
  input  logic             rxValid,
  input  codeHitT          hit,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             txCtlAck,
  output ctlStrbT          strb,
  output logic             txPause,
  output logic             ctlReq,
  output logic             specialHit
);
  pendT pend, pendNext;
  seqT  seq;
  logic setPause, clrPause, dropChar;
  logic sendingXoff, xoffOut;
  logic overTrig, underTrig;

  // Receive-side matching (R2, R3, R4, R6)
  always_comb begin
    setPause = 1'b0;
    clrPause = 1'b0;
    dropChar = 1'b0;
    pendNext = (rxFlowEn && dblMode) ? pend : PEND_NONE;
    if (rxValid && rxFlowEn) begin
      if (!dblMode) begin
        if (hit.xoff1) begin
          setPause = 1'b1;
          dropChar = 1'b1;
        end else if (hit.xon1) begin
          clrPause = 1'b1;
          dropChar = 1'b1;
        end
      end else begin
        if (pend == PEND_XOFF && hit.xoff2) begin
          setPause = 1'b1;
          dropChar = 1'b1;
          pendNext = PEND_NONE;
        end else if (pend == PEND_XON && hit.xon2) begin
          clrPause = 1'b1;
          dropChar = 1'b1;
          pendNext = PEND_NONE;
        end else if (hit.xoff1) begin
          dropChar = 1'b1;
          pendNext = PEND_XOFF;
        end else if (hit.xon1) begin
          dropChar = 1'b1;
          pendNext = PEND_XON;
        end else begin
          pendNext = PEND_NONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend    <= PEND_NONE;
      txPause <= 1'b0;
    end else begin
      pend <= pendNext;
      if (setPause) txPause <= 1'b1;
      else if (clrPause) txPause <= 1'b0;
    end
  end

  assign specialHit = rxValid & specialEn & ~rxFlowEn & hit.xoff2;

  // Threshold-driven transmit requests (R8, R9, R10)
  assign overTrig  = fifoCount > trigLevel;
  assign underTrig = fifoCount < trigLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq         <= SEQ_IDLE;
      sendingXoff <= 1'b0;
      xoffOut     <= 1'b0;
    end else if (seq == SEQ_IDLE) begin
      if (autoEn && !xoffOut && overTrig) begin
        seq         <= SEQ_FIRST;
        sendingXoff <= 1'b1;
        xoffOut     <= 1'b1;
      end else if (autoEn && xoffOut && underTrig) begin
        seq         <= SEQ_FIRST;
        sendingXoff <= 1'b0;
        xoffOut     <= 1'b0;
      end
    end else if (txCtlAck) begin
      seq <= (seq == SEQ_FIRST && dblMode) ? SEQ_SECOND : SEQ_IDLE;
    end
  end

  assign ctlReq          = seq != SEQ_IDLE;
  assign strb.drop       = dropChar;
  assign strb.sendXoff   = sendingXoff;
  assign strb.sendSecond = seq == SEQ_SECOND;

  a_r2_xoff_pauses: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxFlowEn && !dblMode && hit.xoff1) |=> txPause);

  a_r6_pause_holds: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(txPause));

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReq && !txCtlAck) |=> (ctlReq && $stable(strb)));
endmodule

// File: rtl/swFlowCtl.sv
module swFlowCtl
  import flowPkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CHAR_W-1:0] cfgData,
  input  logic              rxFlowEn,
  input  logic              dblMode,
  input  logic              autoEn,
  input  logic              specialEn,
  input  logic [1:0]        wordLen,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic              txCtlAck,
  output logic              txPause,
  output logic              ctlReq,
  output logic [CHAR_W-1:0] ctlChar,
  output logic              fifoWe,
  output logic              specialHit
);
  codeHitT hit;
  ctlStrbT strb;

  flowData #(.CHAR_W(CHAR_W)) uData (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .wordLen(wordLen), .rxValid(rxValid), .rxChar(rxChar), .strb(strb),
    .hit(hit), .fifoWe(fifoWe), .ctlChar(ctlChar)
  );

  flowCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rxFlowEn(rxFlowEn), .dblMode(dblMode),
    .autoEn(autoEn), .specialEn(specialEn), .rxValid(rxValid), .hit(hit),
    .fifoCount(fifoCount), .trigLevel(trigLevel), .txCtlAck(txCtlAck),
    .strb(strb), .txPause(txPause), .ctlReq(ctlReq), .specialHit(specialHit)
  );

  a_r7_special_kept: assert property (@(posedge clk) disable iff (!rstN)
    specialHit |-> fifoWe);
endmodule

// File: tb/sim_swFlowCtl.sv
`timescale 1ns/1ps
module sim_swFlowCtl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       rxFlowEn = 1'b0, dblMode = 1'b0, autoEn = 1'b0, specialEn = 1'b0;
  logic [1:0] wordLen = 2'd3;
  logic       rxValid = 1'b0;
  logic [7:0] rxChar = '0;
  logic [7:0] fifoCount = '0, trigLevel = '0;
  logic       txCtlAck = 1'b0;
  logic       txPause, ctlReq, fifoWe, specialHit;
  logic [7:0] ctlChar;

  int nVec = 0;
  int nBad = 0;
  string curReq = "R6";
  logic [7:0] expQ[$];
  logic lastSpecial;

  always #5 clk = ~clk;

  swFlowCtl u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .rxFlowEn(rxFlowEn), .dblMode(dblMode), .autoEn(autoEn), .specialEn(specialEn),
    .wordLen(wordLen), .rxValid(rxValid), .rxChar(rxChar), .fifoCount(fifoCount),
    .trigLevel(trigLevel), .txCtlAck(txCtlAck), .txPause(txPause), .ctlReq(ctlReq),
    .ctlChar(ctlChar), .fifoWe(fifoWe), .specialHit(specialHit)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: every FIFO write must match the next expected character
  always @(negedge clk) begin
    #2;
    if (rstN && fifoWe) begin
      nVec++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL %s: unexpected write %0h expected no write", curReq, rxChar);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (rxChar !== e) begin
          nBad++;
          $display("FAIL %s: wrote %0h expected %0h", curReq, rxChar, e);
        end
      end
    end
  end

  task automatic sendChar(input logic [7:0] c, input bit written);
    if (written) expQ.push_back(c);
    @(negedge clk);
    rxValid = 1'b1;
    rxChar  = c;
    #3 lastSpecial = specialHit;
    @(negedge clk);
    rxValid = 1'b0;
    #3;
  endtask

  task automatic writeCode(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic stepCycles(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic ackOne;
    @(negedge clk);
    txCtlAck = 1'b1;
    @(negedge clk);
    txCtlAck = 1'b0;
    #3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk("R11 txPause", {7'd0, txPause}, 8'h0);
    chk("R11 ctlReq", {7'd0, ctlReq}, 8'h0);
    rstN = 1'b1;
    stepCycles(1);
    chk("R11 specialHit", {7'd0, specialHit}, 8'h0);

    // R1: codes are zero after reset
    curReq = "R1";
    rxFlowEn = 1'b1;
    sendChar(8'h00, 0);
    chk("R1 zero code pauses", {7'd0, txPause}, 8'h1);
    writeCode(2'd0, 8'h11);
    writeCode(2'd1, 8'h12);
    writeCode(2'd2, 8'h13);
    writeCode(2'd3, 8'h14);
    sendChar(8'h11, 0);
    chk("R1 written resume code", {7'd0, txPause}, 8'h0);

    // R2 / R6 single mode
    curReq = "R2";
    sendChar(8'h41, 1);
    sendChar(8'h13, 0);
    chk("R2 pause set", {7'd0, txPause}, 8'h1);
    curReq = "R6";
    sendChar(8'h41, 1);
    chk("R6 pause held on data", {7'd0, txPause}, 8'h1);
    curReq = "R2";
    sendChar(8'h11, 0);
    chk("R2 pause cleared", {7'd0, txPause}, 8'h0);

    // R5 compare width
    curReq = "R5";
    wordLen = 2'd0;
    sendChar(8'hF3, 0);
    chk("R5 5-bit match", {7'd0, txPause}, 8'h1);
    wordLen = 2'd3;
    sendChar(8'hF1, 1);
    chk("R5 8-bit no match", {7'd0, txPause}, 8'h1);
    wordLen = 2'd0;
    sendChar(8'hF1, 0);
    chk("R5 5-bit resume", {7'd0, txPause}, 8'h0);
    wordLen = 2'd2;
    sendChar(8'h93, 0);
    chk("R5 7-bit match", {7'd0, txPause}, 8'h1);
    wordLen = 2'd3;
    sendChar(8'h11, 0);
    chk("R5 resume", {7'd0, txPause}, 8'h0);

    // R3 / R4 pair mode
    curReq = "R3";
    dblMode = 1'b1;
    sendChar(8'h14, 1);
    chk("R3 lone second code", {7'd0, txPause}, 8'h0);
    sendChar(8'h13, 0);
    chk("R3 half pair", {7'd0, txPause}, 8'h0);
    sendChar(8'h14, 0);
    chk("R3 full pair pauses", {7'd0, txPause}, 8'h1);
    curReq = "R4";
    sendChar(8'h11, 0);
    sendChar(8'h55, 1);
    chk("R4 broken pair", {7'd0, txPause}, 8'h1);
    sendChar(8'h13, 0);
    sendChar(8'h11, 0);
    sendChar(8'h12, 0);
    chk("R4 re-judged first code", {7'd0, txPause}, 8'h0);

    // R6 disabled
    curReq = "R6";
    dblMode = 1'b0;
    rxFlowEn = 1'b0;
    sendChar(8'h13, 1);
    chk("R6 disabled no pause", {7'd0, txPause}, 8'h0);

    // R7 marker mode
    curReq = "R7";
    specialEn = 1'b1;
    sendChar(8'h14, 1);
    chk("R7 marker flagged", {7'd0, lastSpecial}, 8'h1);
    sendChar(8'h41, 1);
    chk("R7 other no flag", {7'd0, lastSpecial}, 8'h0);
    rxFlowEn = 1'b1;
    sendChar(8'h14, 1);
    chk("R7 off with flow on", {7'd0, lastSpecial}, 8'h0);
    specialEn = 1'b0;
    rxFlowEn = 1'b0;

    // R8 / R9 threshold, single codes
    curReq = "R8";
    autoEn = 1'b1;
    trigLevel = 8'd10;
    fifoCount = 8'd10;
    stepCycles(2);
    chk("R8 equal no req", {7'd0, ctlReq}, 8'h0);
    @(negedge clk);
    fifoCount = 8'd11;
    stepCycles(1);
    chk("R8 req raised", {7'd0, ctlReq}, 8'h1);
    chk("R8 pause code", ctlChar, 8'h13);
    stepCycles(2);
    chk("R8 held until ack", {7'd0, ctlReq}, 8'h1);
    ackOne();
    chk("R8 dropped on ack", {7'd0, ctlReq}, 8'h0);
    fifoCount = 8'd12;
    stepCycles(3);
    chk("R8 once per crossing", {7'd0, ctlReq}, 8'h0);
    curReq = "R9";
    fifoCount = 8'd10;
    stepCycles(2);
    chk("R9 equal no resume", {7'd0, ctlReq}, 8'h0);
    @(negedge clk);
    fifoCount = 8'd9;
    stepCycles(1);
    chk("R9 resume req", {7'd0, ctlReq}, 8'h1);
    chk("R9 resume code", ctlChar, 8'h11);
    ackOne();
    chk("R9 dropped on ack", {7'd0, ctlReq}, 8'h0);

    // R10 pair sending
    curReq = "R10";
    dblMode = 1'b1;
    @(negedge clk);
    fifoCount = 8'd11;
    stepCycles(1);
    chk("R10 first pause code", ctlChar, 8'h13);
    ackOne();
    chk("R10 second req", {7'd0, ctlReq}, 8'h1);
    chk("R10 second pause code", ctlChar, 8'h14);
    ackOne();
    chk("R10 done", {7'd0, ctlReq}, 8'h0);
    @(negedge clk);
    fifoCount = 8'd0;
    stepCycles(1);
    chk("R10 first resume code", ctlChar, 8'h11);
    ackOne();
    chk("R10 second resume code", ctlChar, 8'h12);
    ackOne();
    chk("R10 resume done", {7'd0, ctlReq}, 8'h0);

    stepCycles(2);
    chk("R6 all writes seen", 8'(expQ.size()), 8'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule